// File: doc/BRIEF.md
# Return-Status Line Sampler with Parity Check

This block carries a small set of status lines from the far end of a point-to-point link back to the near end over a shared return channel. The transmit half samples its status lines at a fixed rate. A clock divider sets that rate. The transmit half adds an even parity bit to each sample and offers the result as a frame through a valid/ready handshake. The bit-level serialisation onto the physical channel is outside this block.

The receive half accepts frames from the channel. It checks the parity of each frame. It updates its registered status outputs only from frames that pass the check. A frame that fails is dropped. Such a frame increments a saturating error counter and sets a sticky error flag that only reset clears. While the link is reported down, the outputs hold their last values and incoming frames are ignored.

The return lines operate the same way in normal transfer and in self-test operation, so the block has no mode input. With a 40 MHz clock, a divider of 5 gives an 8 MHz sample rate for a single-channel link, and a divider of 8 gives 5 MHz for a dual-channel link.

Top module: `retline_link`

## Requirements
- R1: While link_up is high, a new sample is taken on every DIV-th clock. The first sample is taken on the DIV-th rising edge after reset is released. Each sample makes tx_valid high after that edge.
- R2: A frame carries the sampled lines in bits [LINES-1:0] and a parity bit in bit LINES. The parity bit is chosen so that the XOR of all frame bits is 0.
- R3: A pending frame stays valid and unchanged until a clock edge where tx_ready is high. A new sample that arrives first replaces the pending frame.
- R4: While link_up is low, no sample is taken, and tx_valid is low after the next edge.
- R5: A received frame with rx_valid high, good parity and link_up high places its low LINES bits on status_out after that edge.
- R6: A received frame with bad parity leaves status_out unchanged.
- R7: While link_up is low, status_out, err_count and err_sticky keep their values whatever arrives on the receive side.
- R8: Each bad-parity frame received while link_up is high adds one to err_count. The count saturates at 2**CNT_W-1 (255 by default).
- R9: err_sticky becomes high on the first bad-parity frame and stays high until reset.
- R10: After synchronous reset, tx_valid, tx_frame, status_out, err_count and err_sticky are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | High while the link is operational |
| status_in | input | LINES | Status lines sampled by the transmit half |
| tx_frame | output | LINES+1 | Outgoing frame: parity bit on top, data below |
| tx_valid | output | 1 | Outgoing frame is valid |
| tx_ready | input | 1 | Return channel accepts the outgoing frame |
| rx_frame | input | LINES+1 | Incoming frame from the return channel |
| rx_valid | input | 1 | Incoming frame is valid for one cycle |
| status_out | output | LINES | Last status value that passed the parity check |
| err_count | output | CNT_W | Saturating count of bad-parity frames |
| err_sticky | output | 1 | Set by any bad-parity frame, cleared by reset |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that rx_valid marks each received frame for exactly one cycle. The receive half has no back-pressure, so a frame held over two cycles would count as two frames. The bench drives every input at the falling edge and presents a new random frame on each valid cycle. It mixes random ready back-pressure, link-down stretches that overlap pending frames, and a long run of corrupted frames that takes the error counter past its saturation point.

// File: rtl/rl_divider.sv
module rl_divider #(
  parameter int unsigned DIV = 5
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/rl_sender.sv
module rl_sender #(
  parameter int unsigned LINES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic             tick,
  input  logic [LINES-1:0] lines,
  input  logic             ready,
  output logic [LINES:0]   frame,
  output logic             valid
);
  logic [LINES:0] frame_q;
  logic           valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      valid_q <= 1'b0;
    end else if (!link_up) begin
      valid_q <= 1'b0;
    end else if (tick) begin
      frame_q <= {^lines, lines};
      valid_q <= 1'b1;
    end else if (valid_q && ready) begin
      valid_q <= 1'b0;
    end
  end

  assign frame = frame_q;
  assign valid = valid_q;

  // R2
  frame_parity_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (^frame == 1'b0));
  // R3
  pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (link_up && valid && !ready && !tick) |=> (valid && $stable(frame)));
  // R4
  link_down_chk: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> !valid);
endmodule

// File: rtl/rl_receiver.sv
module rl_receiver #(
  parameter int unsigned LINES = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic [LINES:0]   frame,
  input  logic             valid,
  output logic [LINES-1:0] status,
  output logic [CNT_W-1:0] errs,
  output logic             sticky
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             accept;
  logic             par_bad;
  logic [LINES-1:0] status_q;
  logic [CNT_W-1:0] errs_q;
  logic             sticky_q;

  assign accept  = valid && link_up;
  assign par_bad = ^frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      errs_q   <= '0;
      sticky_q <= 1'b0;
    end else if (accept) begin
      if (!par_bad) begin
        status_q <= frame[LINES-1:0];
      end else begin
        sticky_q <= 1'b1;
        if (errs_q != CMAX) errs_q <= errs_q + 1'b1;
      end
    end
  end

  assign status = status_q;
  assign errs   = errs_q;
  assign sticky = sticky_q;

  // R6
  bad_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && (^frame)) |=> $stable(status));
  // R7
  down_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> ($stable(status) && $stable(errs) && $stable(sticky)));
  // R8
  sat_chk: assert property (@(posedge clk) disable iff (rst)
    (errs == CMAX) |=> (errs == CMAX));
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sticky |=> sticky);
endmodule

// File: rtl/retline_link.sv
module retline_link #(
  parameter int unsigned LINES = 4,
  parameter int unsigned DIV   = 5,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic [LINES-1:0] status_in,
  output logic [LINES:0]   tx_frame,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic [LINES:0]   rx_frame,
  input  logic             rx_valid,
  output logic [LINES-1:0] status_out,
  output logic [CNT_W-1:0] err_count,
  output logic             err_sticky
);
  logic tick;

  rl_divider #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  rl_sender #(.LINES(LINES)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .link_up (link_up),
    .tick    (tick),
    .lines   (status_in),
    .ready   (tx_ready),
    .frame   (tx_frame),
    .valid   (tx_valid)
  );

  rl_receiver #(.LINES(LINES), .CNT_W(CNT_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .link_up (link_up),
    .frame   (rx_frame),
    .valid   (rx_valid),
    .status  (status_out),
    .errs    (err_count),
    .sticky  (err_sticky)
  );
endmodule

// File: tb/retline_link_tb.sv
module retline_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 4;
  localparam int DIV   = 5;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             link_up = 1'b0;
  logic [LINES-1:0] status_in = '0;
  logic [LINES:0]   tx_frame;
  logic             tx_valid;
  logic             tx_ready = 1'b0;
  logic [LINES:0]   rx_frame = '0;
  logic             rx_valid = 1'b0;
  logic [LINES-1:0] status_out;
  logic [CNT_W-1:0] err_count;
  logic             err_sticky;

  int n_checks = 0;
  int n_fails  = 0;

  // behavioural reference state
  int             m_cnt = 0;
  int             m_err = 0;
  bit             m_v = 0;
  bit             m_sticky = 0;
  bit [LINES:0]   m_f = '0;
  bit [LINES-1:0] m_st = '0;
  int             cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  retline_link #(.LINES(LINES), .DIV(DIV), .CNT_W(CNT_W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .link_up    (link_up),
    .status_in  (status_in),
    .tx_frame   (tx_frame),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_frame   (rx_frame),
    .rx_valid   (rx_valid),
    .status_out (status_out),
    .err_count  (err_count),
    .err_sticky (err_sticky)
  );

  always @(posedge clk) begin
    bit tk;
    if (rst) begin
      m_cnt = 0; m_err = 0; m_v = 0; m_sticky = 0; m_f = '0; m_st = '0;
    end else begin
      tk = (m_cnt == DIV - 1);
      m_cnt = tk ? 0 : m_cnt + 1;
      if (!link_up) m_v = 0;
      else if (tk) begin
        m_f = {^status_in, status_in};
        m_v = 1;
      end else if (m_v && tx_ready) m_v = 0;
      if (link_up && rx_valid) begin
        if (^rx_frame == 1'b0) m_st = rx_frame[LINES-1:0];
        else begin
          m_sticky = 1;
          if (m_err < CMAX) m_err = m_err + 1;
        end
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s cycle %0d got %0h expected %0h", req, cyc, got, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1/R3/R4 tx_valid", int'(tx_valid), int'(m_v));
    if (m_v) chk("R2/R3 tx_frame", int'(tx_frame), int'(m_f));
    chk("R5/R6/R7 status_out", int'(status_out), int'(m_st));
    chk("R8 err_count", int'(err_count), m_err);
    chk("R9 err_sticky", int'(err_sticky), int'(m_sticky));
  endtask

  function automatic logic [LINES:0] mk_frame(logic [LINES-1:0] d, bit bad);
    return {(^d) ^ bad, d};
  endfunction

  // one cycle: compare at falling edge, then drive new inputs
  task automatic step(bit lk, int ready_pct, int rxv_pct, int bad_pct);
    @(negedge clk);
    cyc++;
    compare_all();
    link_up   = lk;
    status_in = LINES'($urandom);
    tx_ready  = (($urandom % 100) < ready_pct);
    rx_valid  = (($urandom % 100) < rxv_pct);
    rx_frame  = mk_frame(LINES'($urandom), (($urandom % 100) < bad_pct));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 tx_valid", int'(tx_valid), 0);
    chk("R10 tx_frame", int'(tx_frame), 0);
    chk("R10 status_out", int'(status_out), 0);
    chk("R10 err_count", int'(err_count), 0);
    chk("R10 err_sticky", int'(err_sticky), 0);
    rst = 1'b0;
    link_up = 1'b1;
    // R1 R2 R5: always ready, good frames only
    repeat (60) step(1, 100, 50, 0);
    // R3: heavy back-pressure
    repeat (100) step(1, 10, 30, 0);
    // R6: mixed good and bad frames
    repeat (200) step(1, 50, 60, 30);
    // R4 R7: link down with traffic
    repeat (80) step(0, 50, 80, 50);
    repeat (40) step(1, 0, 50, 10);
    repeat (30) step(0, 0, 100, 100);
    // R8: saturation run of bad frames
    repeat (320) step(1, 50, 100, 100);
    // R9: good frames after errors, sticky stays
    repeat (100) step(1, 70, 60, 0);
    repeat (20) step(0, 70, 60, 50);
    @(negedge clk);
    cyc++;
    compare_all();
    chk("R8 saturated", int'(err_count), CMAX);
    chk("R9 sticky held", int'(err_sticky), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule